// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block is a slave receiver for stereo PCM audio carried on three wires: a bit clock, a word-select clock that marks the two halves of each stereo frame, and a serial data line. All three are oversampled in the system clock domain through two-flop synchronisers. The block counts the bits in each half-frame and picks the sample out of the slots that the selected framing format defines. It then presents a left and a right 24-bit two's-complement sample together with a single-cycle strobe.

A 2-bit format input selects the framing. Format 0 carries a 16-bit sample that ends on the last slot of its half-frame. Format 1 carries a 24-bit sample aligned the same way. Format 2 carries a 24-bit sample that starts on the first slot after the word-select edge. Format 3 is I2S style: the MSB comes one bit clock after the word-select edge. In that format a 32fs stream yields 16-bit words that are zero-filled at the bottom. The format is latched while the receiver waits for framing. Any change to it while frames are being received stops the receiver until the next reset. Each half-frame must be long enough for the selected format, and a frame with a half that is too short is discarded.

The control is a five-state machine. ST_IDLE waits for the first bit clock rise and then moves to ST_WAIT. ST_WAIT holds until a word-select edge opens a left half, then moves to ST_LEFT. ST_LEFT moves to ST_RIGHT on the next edge. ST_RIGHT returns to ST_LEFT on the next edge, and that transition publishes the frame. A format change in ST_LEFT or ST_RIGHT moves the machine to ST_HALT, which it leaves only through reset.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is asserted and right after it is released, left_o and right_o are zero and valid_o is low.
- R2: Data is sampled on rising edges of the bit clock, MSB first, and taken as two's complement: a sample whose MSB is 1 comes out negative.
- R3: With fmt_i = 0, the last 16 slots of a half-frame form the sample and earlier slots are ignored. The output is the 16-bit value in bits 23:8, with bits 7:0 zero.
- R4: With fmt_i = 1, the last 24 slots of a half-frame form the sample and earlier slots are ignored.
- R5: With fmt_i = 2, the first 24 slots after the word-select edge form the sample and later slots are ignored.
- R6: With fmt_i = 3, the left channel runs while word-select is low and the MSB is in the slot one bit clock after the edge. With 24 or more slots per half, the first 24 slots form the sample. With exactly 16 slots per half, they fill bits 23:8 and bits 7:0 are zero.
- R7: With fmt_i = 0, 1 or 2, the half-frame with word-select high is the left channel, and the half that follows is the right channel.
- R8: The slots per half-frame must be at least 16 for fmt_i = 0, at least 24 for fmt_i = 1 or 2, and exactly 16 or at least 24 for fmt_i = 3. A frame with a shorter half gives no strobe and leaves the outputs unchanged.
- R9: valid_o pulses for exactly one clock per accepted stereo frame, after its right half ends. left_o and right_o change only on that pulse.
- R10: If fmt_i changes while frames are being received, the current and all later frames give no strobe and the outputs hold until reset.
- R11: After reset, the partial half-frame in progress is dropped. The first strobe comes from the first left half that starts on a word-select edge and the right half that follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| wsel_i | input | 1 | Word-select (frame) clock, asynchronous |
| sdata_i | input | 1 | Serial data line |
| fmt_i | input | 2 | Framing format select, 0 to 3 |
| left_o | output | 24 | Left sample, two's complement |
| right_o | output | 24 | Right sample, two's complement |
| valid_o | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
Each format is run with half-frames of 16, 24 and 32 slots, and the padding slots are filled with random bits. This tells apart samples aligned to the end of the half from samples aligned to its start, and it catches an off-by-one slot in the I2S delay. Negative samples show whether sign bits land at bit 23 after 16-bit widening. Half-frames too short for the format, a format change in the middle of a frame, and a stream that starts in the middle of a half check that bad frames produce no strobe and leave the outputs as they were.

// File: rtl/arx_pkg.sv
package arx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LEFT,
        ST_RIGHT,
        ST_HALT
    } rx_state_e;

    typedef enum logic [1:0] {
        FMT_TAIL16 = 2'd0,
        FMT_TAIL24 = 2'd1,
        FMT_HEAD24 = 2'd2,
        FMT_DELAY  = 2'd3
    } rx_fmt_e;

endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d_i;
            for (int k = 1; k < STAGES; k++) begin
                pipe[k] <= pipe[k-1];
            end
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/arx_slot.sv
module arx_slot #(
    parameter int DW    = 24,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_rise,
    input  logic             ws,
    input  logic             sd,
    input  logic             delay_ws,
    output logic             evt,
    output logic             new_left,
    output logic [CNT_W-1:0] len,
    output logic [DW-1:0]    tail_bits,
    output logic [DW-1:0]    head_bits
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] HEAD_IDX = CNT_W'(DW - 1);

    logic             ws_d;
    logic             ws_last;
    logic             ws_eff;
    logic [CNT_W-1:0] cnt;
    logic [DW-1:0]    sh;
    logic [DW-1:0]    head;

    // delayed framing: the half starts one bit clock after the raw edge
    assign ws_eff   = delay_ws ? ~ws_d : ws;
    assign evt      = bit_rise && (ws_eff != ws_last);
    assign new_left = ws_eff;
    assign len       = cnt;
    assign tail_bits = sh;
    assign head_bits = head;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_d    <= 1'b0;
            ws_last <= 1'b0;
            cnt     <= '0;
            sh      <= '0;
            head    <= '0;
        end else if (bit_rise) begin
            ws_d    <= ws;
            ws_last <= ws_eff;
            sh      <= {sh[DW-2:0], sd};
            if (evt) begin
                cnt <= CNT_W'(1);
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + CNT_W'(1);
            end
            if (!evt && cnt == HEAD_IDX) begin
                head <= {sh[DW-2:0], sd};
            end
        end
    end

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (cnt == CNT_W'(1))); // R4
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_rise |=> $stable(cnt)); // R2
endmodule

// File: rtl/arx_align.sv
module arx_align
    import arx_pkg::*;
#(
    parameter int DW    = 24,
    parameter int SW    = 16,
    parameter int CNT_W = 7
) (
    input  rx_fmt_e          fmt,
    input  logic [CNT_W-1:0] len,
    input  logic [DW-1:0]    tail_bits,
    input  logic [DW-1:0]    head_bits,
    output logic [DW-1:0]    word,
    output logic             ok
);
    localparam int PAD = DW - SW;
    localparam logic [CNT_W-1:0] LEN_S = CNT_W'(SW);
    localparam logic [CNT_W-1:0] LEN_L = CNT_W'(DW);

    logic [DW-1:0] short_word;
    assign short_word = {tail_bits[SW-1:0], {PAD{1'b0}}};

    always_comb begin
        word = '0;
        ok   = 1'b0;
        unique case (fmt)
            FMT_TAIL16: begin
                word = short_word;
                ok   = (len >= LEN_S);
            end
            FMT_TAIL24: begin
                word = tail_bits;
                ok   = (len >= LEN_L);
            end
            FMT_HEAD24: begin
                word = head_bits;
                ok   = (len >= LEN_L);
            end
            FMT_DELAY: begin
                word = (len == LEN_S) ? short_word : head_bits;
                ok   = (len == LEN_S) || (len >= LEN_L);
            end
        endcase
    end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
    import arx_pkg::*;
#(
    parameter int DW          = 24,
    parameter int SW          = 16,
    parameter int CNT_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bclk_i,
    input  logic          wsel_i,
    input  logic          sdata_i,
    input  logic [1:0]    fmt_i,
    output logic [DW-1:0] left_o,
    output logic [DW-1:0] right_o,
    output logic          valid_o
);
    logic [2:0]       pins_s;
    logic             bclk_q;
    logic             bit_rise;
    logic             evt;
    logic             new_left;
    logic [CNT_W-1:0] len;
    logic [DW-1:0]    tail_bits;
    logic [DW-1:0]    head_bits;
    logic [DW-1:0]    word;
    logic             word_ok;
    rx_fmt_e          fmt_run;
    rx_state_e        state;
    rx_state_e        state_nx;
    logic             fmt_chg;
    logic [DW-1:0]    left_hold;
    logic             left_ok;

    arx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({bclk_i, wsel_i, sdata_i}),
        .q_o   (pins_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_q <= 1'b0;
        else        bclk_q <= pins_s[2];
    end
    assign bit_rise = pins_s[2] & ~bclk_q;

    arx_slot #(.DW(DW), .CNT_W(CNT_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_rise  (bit_rise),
        .ws        (pins_s[1]),
        .sd        (pins_s[0]),
        .delay_ws  (fmt_run == FMT_DELAY),
        .evt       (evt),
        .new_left  (new_left),
        .len       (len),
        .tail_bits (tail_bits),
        .head_bits (head_bits)
    );

    arx_align #(.DW(DW), .SW(SW), .CNT_W(CNT_W)) u_align (
        .fmt       (fmt_run),
        .len       (len),
        .tail_bits (tail_bits),
        .head_bits (head_bits),
        .word      (word),
        .ok        (word_ok)
    );

    assign fmt_chg = ((state == ST_LEFT) || (state == ST_RIGHT)) &&
                     (rx_fmt_e'(fmt_i) != fmt_run);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (bit_rise)             state_nx = ST_WAIT;
            ST_WAIT:  if (evt && new_left)      state_nx = ST_LEFT;
            ST_LEFT:  if (fmt_chg)              state_nx = ST_HALT;
                      else if (evt)             state_nx = ST_RIGHT;
            ST_RIGHT: if (fmt_chg)              state_nx = ST_HALT;
                      else if (evt)             state_nx = ST_LEFT;
            ST_HALT:                            state_nx = ST_HALT;
        endcase
    end

    // outputs and capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_run   <= FMT_TAIL16;
            left_hold <= '0;
            left_ok   <= 1'b0;
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            unique case (state)
                ST_IDLE, ST_WAIT: begin
                    fmt_run <= rx_fmt_e'(fmt_i);
                    left_ok <= 1'b0;
                end
                ST_LEFT: begin
                    if (evt && !fmt_chg) begin
                        left_hold <= word;
                        left_ok   <= word_ok;
                    end
                end
                ST_RIGHT: begin
                    if (evt && !fmt_chg && word_ok && left_ok) begin
                        left_o  <= left_hold;
                        right_o <= word;
                        valid_o <= 1'b1;
                    end
                end
                ST_HALT: begin
                    left_ok <= 1'b0;
                end
            endcase
        end
    end

    AST_VALID_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(evt)); // R9
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R9
    AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(left_o)); // R9
    AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(right_o)); // R9
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> (state == ST_HALT)); // R10
    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> !valid_o); // R10
    AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) || (state == ST_WAIT)) |=> !valid_o); // R11
endmodule

// File: tb/audio_serial_rx_tb_top.sv
module audio_serial_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        wsel = 1'b0;
    logic        sdata = 1'b0;
    logic [1:0]  fmt = 2'd0;
    logic [23:0] left_o;
    logic [23:0] right_o;
    logic        valid_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [23:0] exp_l[$];
    logic [23:0] exp_r[$];
    string       exp_tag[$];
    logic [23:0] last_l = '0;
    logic [23:0] last_r = '0;
    logic        valid_prev = 1'b0;
    int          cyc = 0;

    always #5 clk = ~clk;

    audio_serial_rx dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_i  (bclk),
        .wsel_i  (wsel),
        .sdata_i (sdata),
        .fmt_i   (fmt),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_o && valid_prev) check("R9 strobe width", 48'd2, 48'd1);
            if (valid_o) begin
                if (exp_l.size() == 0) begin
                    check("R9 unexpected strobe", {left_o, right_o}, 48'd0);
                end else begin
                    automatic string t = exp_tag.pop_front();
                    automatic logic [23:0] el = exp_l.pop_front();
                    automatic logic [23:0] er = exp_r.pop_front();
                    check(t, {left_o, right_o}, {el, er});
                    last_l = left_o;
                    last_r = right_o;
                end
            end
            valid_prev = valid_o;
        end else begin
            valid_prev = 1'b0;
        end
    end

    task automatic do_reset(input logic [1:0] f);
        rst_n = 1'b0;
        fmt   = f;
        bclk  = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_bit(input logic w, input logic d);
        @(negedge clk);
        bclk  = 1'b0;
        wsel  = w;
        sdata = d;
        repeat (4) @(negedge clk);
        bclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic slot_bit(input int f, input int n, input int i, input logic [23:0] s);
        int b;
        logic junk;
        junk = 1'($urandom % 2);
        case (f)
            0: begin b = n - 1 - i; return (b < 16) ? s[b] : junk; end
            1: begin b = n - 1 - i; return (b < 24) ? s[b] : junk; end
            default: return (i < 24) ? s[23-i] : junk;
        endcase
    endfunction

    function automatic logic [23:0] exp_word(input int f, input int n, input logic [23:0] s);
        case (f)
            0: return {s[15:0], 8'h00};
            3: return (n == 16) ? {s[23:8], 8'h00} : s;
            default: return s;
        endcase
    endfunction

    // one half-frame, laid out in effective (post-delay) slots
    task automatic send_half(input int f, input int n, input logic is_left,
                             input logic [23:0] s, input int stop_at);
        for (int i = 0; i < n; i++) begin
            logic w;
            if (f == 3) w = (i == n - 1) ? is_left : ~is_left;
            else        w = is_left;
            if (i == stop_at) fmt = fmt + 2'd1;
            send_bit(w, slot_bit(f, n, i, s));
        end
    endtask

    task automatic send_frame(input int f, input int n, input logic [23:0] l,
                              input logic [23:0] r, input logic expect_it, input string tag);
        if (expect_it) begin
            exp_l.push_back(exp_word(f, n, l));
            exp_r.push_back(exp_word(f, n, r));
            exp_tag.push_back(tag);
        end
        send_half(f, n, 1'b1, l, -1);
        send_half(f, n, 1'b0, r, -1);
    endtask

    task automatic finish_run(input int f, input int n, input string tag);
        send_half(f, n, 1'b1, 24'h0, -1);
        repeat (20) @(negedge clk);
        check({tag, " pending frames"}, 48'(exp_l.size()), 48'd0);
        exp_l.delete(); exp_r.delete(); exp_tag.delete();
    endtask

    task automatic run_fmt(input int f, input int n, input string tag);
        do_reset(2'(f));
        send_half(f, n, 1'b0, 24'h0, -1);
        send_frame(f, n, 24'h8A5C31, 24'h13F0E7, 1'b1, tag);
        send_frame(f, n, 24'hF00F5A, 24'h7FFFFF, 1'b1, tag);
        send_frame(f, n, 24'h800001, 24'h00C3A5, 1'b1, tag);
        finish_run(f, n, tag);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_chk++;
                n_bad++;
                $display("FAIL R9 watchdog actual=timeout expected=finish");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {left_o, right_o}, 48'd0);
        check("R1 reset strobe", 48'(valid_o), 48'd0);
        do_reset(2'd0);
        check("R1 after release", {left_o, right_o, 24'(valid_o)} >> 0, 48'd0);

        // R2 R7 R4: tail-aligned 24-bit, several ratios, junk in lead slots
        run_fmt(1, 32, "R4 fmt1 64fs");
        run_fmt(1, 24, "R4 fmt1 48fs");
        // R3: tail-aligned 16-bit widened
        run_fmt(0, 32, "R3 fmt0 64fs");
        run_fmt(0, 16, "R3 fmt0 32fs");
        // R5: head-aligned 24-bit, junk after
        run_fmt(2, 32, "R5 fmt2 64fs");
        run_fmt(2, 24, "R5 fmt2 48fs");
        // R6: delayed framing
        run_fmt(3, 32, "R6 fmt3 64fs");
        run_fmt(3, 16, "R6 fmt3 32fs");

        // R8: too-short halves are dropped, outputs hold
        do_reset(2'd1);
        send_half(1, 32, 1'b0, 24'h0, -1);
        send_frame(1, 32, 24'h123456, 24'hABCDEF, 1'b1, "R8 good before");
        send_frame(1, 16, 24'h0F0F0F, 24'hF0F0F0, 1'b0, "");
        send_frame(1, 20, 24'h0F0F0F, 24'hF0F0F0, 1'b0, "");
        finish_run(1, 20, "R8 fmt1 short");
        check("R8 outputs held", {left_o, right_o}, {24'h123456, 24'hABCDEF});

        do_reset(2'd3);
        send_half(3, 20, 1'b0, 24'h0, -1);
        send_frame(3, 20, 24'h5A5A5A, 24'hA5A5A5, 1'b0, "");
        send_frame(3, 20, 24'h5A5A5A, 24'hA5A5A5, 1'b0, "");
        finish_run(3, 20, "R8 fmt3 40fs");
        check("R8 fmt3 held at reset value", {left_o, right_o}, 48'd0);

        do_reset(2'd0);
        send_half(0, 12, 1'b0, 24'h0, -1);
        send_frame(0, 12, 24'h00FFFF, 24'h00FFFF, 1'b0, "");
        finish_run(0, 12, "R8 fmt0 24fs");

        // R10: format change mid-frame halts
        do_reset(2'd1);
        send_half(1, 32, 1'b0, 24'h0, -1);
        send_frame(1, 32, 24'hC0FFEE, 24'h0BADF0, 1'b1, "R10 before change");
        send_half(1, 32, 1'b1, 24'h111111, 10);
        send_half(1, 32, 1'b0, 24'h222222, -1);
        send_frame(1, 32, 24'h333333, 24'h444444, 1'b0, "");
        finish_run(1, 32, "R10 halted");
        check("R10 outputs held", {left_o, right_o}, {24'hC0FFEE, 24'h0BADF0});

        // R11: start mid-half, partial half dropped
        do_reset(2'd1);
        for (int i = 0; i < 10; i++) send_bit(1'b1, 1'b1);
        send_half(1, 32, 1'b0, 24'h777777, -1);
        send_frame(1, 32, 24'h246801, 24'hFEDCBA, 1'b1, "R11 first full frame");
        finish_run(1, 32, "R11 partial start");

        // R9: reset clears after a run
        do_reset(2'd2);
        check("R1 R9 reset clears outputs", {left_o, right_o}, 48'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule